// File: doc/BRIEF.md
# Indexed Channel Flag Clear Port

This block keeps a 32-entry register of per-channel flags, such as pending interrupt requests, and offers a write-only command port to clear them. Channels raise their own flag with a one-cycle set pulse. Software clears flags by writing command bytes. Each byte names one channel to clear, asks for every flag to be cleared, or does nothing. The interrupt output is high whenever any flag is set.

The command port sits on a 32-bit write bus with byte enables. Each enabled byte lane is decoded as a separate command, so up to four commands can share one word. A byte whose no-operation bit is set is ignored. This lets software write a whole word across adjacent byte-wide command slots while only the intended bytes act. The flag register can be read at its own word address. Reads of the command address return zero.

Top module: `flag_clear_port`

## Requirements
- R1: After reset every flag is 0, `irq` is low, and a read of the flag address returns 0.
- R2: A 1 on `chan_set[i]` at a clock edge sets flag i from that edge onward. `irq` is high exactly when at least one flag is 1.
- R3: A command byte with bit 7 = 0 and bits 6:0 in the range 0 to 31 clears only the flag of the channel with that number. The clear takes effect on the edge that accepts the write.
- R4: A command byte with bit 7 = 0 and bit 6 = 1 (codes 64 to 127) clears all flags.
- R5: A command byte with bit 7 = 0 and bits 6:0 in the range 32 to 63 (bit 6 = 0, bit 5 = 1) changes no flag.
- R6: A command byte with bit 7 = 1 changes no flag, whatever its lower seven bits hold.
- R7: Byte lane k is `bus_wdata[8k+7:8k]`. It is decoded only when `bus_be[k]` is 1. All enabled lanes of one write act on the same edge, and their clears are combined.
- R8: When a set pulse and a clear for the same channel meet at the same edge, the flag ends up set.
- R9: A write to the command address (`CMD_ADDR`, default 7) acts. A write to any other address, including the flag address (`FLAG_ADDR`, default 4), changes no flag. A read of the command address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data, four command byte lanes |
| bus_be | input | 4 | Byte enables, one per lane |
| bus_rdata | output | 32 | Read data; combinational from the flag register |
| chan_set | input | 32 | Per-channel set pulses |
| flags_out | output | 32 | Current flag register |
| irq | output | 1 | OR of all flags |

## Verification
The hardest situation to reach is a single write that holds several lanes of different kinds: a single-channel clear next to a reserved code, a no-op byte and a disabled lane. A set pulse for one of the cleared channels may arrive on the same edge. Directed words build these mixes on purpose. Random traffic then draws each lane's kind (single, global, reserved, no-op, raw) separately, together with sparse random set pulses. This exercises every lane combination against a bench model of the flags.

// File: rtl/fcp_pkg.sv
package fcp_pkg;
   localparam int CMD_W  = 8;
   localparam int CODE_W = CMD_W - 1;

   typedef struct packed {
      logic              skip;
      logic [CODE_W-1:0] code;
   } cmd_t;
endpackage

// File: rtl/fcp_lane_decode.sv
module fcp_lane_decode #(
   parameter int NUM_CHAN = 32
) (
   input  logic                en,
   input  fcp_pkg::cmd_t       cmd,
   output logic [NUM_CHAN-1:0] clr_mask
);
   localparam int GLOBAL_BIT = fcp_pkg::CODE_W - 1;

   logic active;
   logic wipe;

   assign active = en & ~cmd.skip;
   assign wipe   = active & cmd.code[GLOBAL_BIT];

   // codes at or above NUM_CHAN but below the global range match no bit
   for (genvar i = 0; i < NUM_CHAN; i++) begin : g_bit
      assign clr_mask[i] = wipe | (active & (cmd.code == fcp_pkg::CODE_W'(i)));
   end
endmodule

// File: rtl/fcp_flag_store.sv
module fcp_flag_store #(
   parameter int NUM_CHAN = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_CHAN-1:0] set_vec,
   input  logic [NUM_CHAN-1:0] clr_vec,
   output logic [NUM_CHAN-1:0] flags
);
   for (genvar i = 0; i < NUM_CHAN; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags[i] <= 1'b0;
         else if (set_vec[i])
            flags[i] <= 1'b1;
         else if (clr_vec[i])
            flags[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/fcp_read_mux.sv
module fcp_read_mux #(
   parameter int          NUM_CHAN  = 32,
   parameter int          DATA_W    = 32,
   parameter int          ADDR_W    = 4,
   parameter logic [15:0] FLAG_ADDR = 16'd4
) (
   input  logic                rd,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [NUM_CHAN-1:0] flags,
   output logic [DATA_W-1:0]   rdata
);
   logic hit;
   assign hit = rd && (addr == FLAG_ADDR[ADDR_W-1:0]);

   always_comb begin
      rdata = '0;
      if (hit)
         rdata[NUM_CHAN-1:0] = flags;
   end
endmodule

// File: rtl/flag_clear_port.sv
module flag_clear_port #(
   parameter int          NUM_CHAN  = 32,
   parameter int          DATA_W    = 32,
   parameter int          ADDR_W    = 4,
   parameter logic [15:0] CMD_ADDR  = 16'd7,
   parameter logic [15:0] FLAG_ADDR = 16'd4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   input  logic [DATA_W/8-1:0] bus_be,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_CHAN-1:0] chan_set,
   output logic [NUM_CHAN-1:0] flags_out,
   output logic                irq
);
   localparam int LANES = DATA_W / fcp_pkg::CMD_W;

   if (NUM_CHAN < 1 || NUM_CHAN > 32) begin : g_bad_chan
      $error("NUM_CHAN must lie in 1..32");
   end
   if (DATA_W != LANES * fcp_pkg::CMD_W || LANES < 1) begin : g_bad_width
      $error("DATA_W must be a positive multiple of 8");
   end
   if (NUM_CHAN > DATA_W) begin : g_bad_read
      $error("flag register must fit in one data word");
   end
   if (CMD_ADDR[ADDR_W-1:0] == FLAG_ADDR[ADDR_W-1:0]) begin : g_bad_addr
      $error("command and flag addresses must differ");
   end
   if (ADDR_W < 16 && ((CMD_ADDR >> ADDR_W) != 0 || (FLAG_ADDR >> ADDR_W) != 0)) begin : g_bad_range
      $error("addresses must fit in ADDR_W bits");
   end

   logic                cmd_hit;
   logic [NUM_CHAN-1:0] lane_clr [LANES];
   logic [NUM_CHAN-1:0] clr_all_lanes;

   assign cmd_hit = bus_wr && (bus_addr == CMD_ADDR[ADDR_W-1:0]);

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      fcp_lane_decode #(.NUM_CHAN(NUM_CHAN)) u_dec (
         .en       (cmd_hit & bus_be[k]),
         .cmd      (bus_wdata[k*fcp_pkg::CMD_W +: fcp_pkg::CMD_W]),
         .clr_mask (lane_clr[k])
      );
   end

   always_comb begin
      clr_all_lanes = '0;
      for (int k = 0; k < LANES; k++)
         clr_all_lanes = clr_all_lanes | lane_clr[k];
   end

   fcp_flag_store #(.NUM_CHAN(NUM_CHAN)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (chan_set),
      .clr_vec (clr_all_lanes),
      .flags   (flags_out)
   );

   fcp_read_mux #(
      .NUM_CHAN  (NUM_CHAN),
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .FLAG_ADDR (FLAG_ADDR)
   ) u_rd (
      .rd    (bus_rd),
      .addr  (bus_addr),
      .flags (flags_out),
      .rdata (bus_rdata)
   );

   assign irq = |flags_out;
endmodule

// File: rtl/fcp_checker.sv
module fcp_checker #(
   parameter int          NUM_CHAN  = 32,
   parameter int          DATA_W    = 32,
   parameter int          ADDR_W    = 4,
   parameter logic [15:0] CMD_ADDR  = 16'd7
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_wr,
   input logic                bus_rd,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic [DATA_W/8-1:0] bus_be,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic [NUM_CHAN-1:0] chan_set,
   input logic [NUM_CHAN-1:0] flags_out,
   input logic                irq
);
   localparam int LANES = DATA_W / 8;

   logic to_cmd;
   logic any_wipe;
   logic all_skip;

   assign to_cmd = bus_wr && (bus_addr == CMD_ADDR[ADDR_W-1:0]);

   always_comb begin
      any_wipe = 1'b0;
      all_skip = 1'b1;
      for (int k = 0; k < LANES; k++) begin
         if (bus_be[k] && !bus_wdata[8*k+7]) begin
            all_skip = 1'b0;
            if (bus_wdata[8*k+6])
               any_wipe = 1'b1;
         end
      end
   end

   p_cmd_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == CMD_ADDR[ADDR_W-1:0]) |-> (bus_rdata == '0));

   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|chan_set) |=> ((flags_out & $past(chan_set)) == $past(chan_set)));

   p_no_clear_off_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !to_cmd |=> (($past(flags_out) & ~flags_out) == '0));

   p_skip_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (to_cmd && all_skip) |=> (($past(flags_out) & ~flags_out) == '0));

   p_wipe_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (to_cmd && any_wipe && chan_set == '0) |=> (flags_out == '0));

   p_irq_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_out == '0) |-> !irq);
endmodule

bind flag_clear_port fcp_checker #(
   .NUM_CHAN (NUM_CHAN),
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .CMD_ADDR (CMD_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_be    (bus_be),
   .bus_rdata (bus_rdata),
   .chan_set  (chan_set),
   .flags_out (flags_out),
   .irq       (irq)
);

// File: tb/flag_clear_port_test.sv
`timescale 1ns/1ps
module flag_clear_port_test;
   localparam logic [3:0] CMD_A  = 4'd7;
   localparam logic [3:0] FLAG_A = 4'd4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_rdata;
   logic [31:0] chan_set = '0;
   logic [31:0] flags_out;
   logic        irq;

   int total = 0;
   int bad = 0;
   logic [31:0] exp_f = '0;

   always #2.5 clk = ~clk;

   flag_clear_port uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
      .bus_rdata(bus_rdata), .chan_set(chan_set), .flags_out(flags_out),
      .irq(irq)
   );

   function automatic logic [31:0] model(input logic [31:0] f, input logic wr,
         input logic [3:0] a, input logic [31:0] d, input logic [3:0] be,
         input logic [31:0] s);
      logic [31:0] c = '0;
      if (wr && a == CMD_A) begin
         for (int k = 0; k < 4; k++) begin
            logic [7:0] b = d[8*k +: 8];
            if (be[k] && !b[7]) begin
               if (b[6]) c = '1;
               else if (b[6:0] < 7'd32) c[b[4:0]] = 1'b1;
            end
         end
      end
      return (f & ~c) | s;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input string req, input logic wr, input logic [3:0] a,
         input logic [31:0] d, input logic [3:0] be, input logic [31:0] s);
      @(negedge clk);
      bus_wr = wr; bus_addr = a; bus_wdata = d; bus_be = be; chan_set = s;
      @(posedge clk);
      exp_f = model(exp_f, wr, a, d, be, s);
      #1;
      bus_wr = 1'b0; bus_be = '0; chan_set = '0;
      chk(req, flags_out, exp_f);
      chk({req, " irq"}, {31'b0, irq}, {31'b0, |exp_f});
   endtask

   task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1;
      chk(req, bus_rdata, exp);
      bus_rd = 1'b0;
   endtask

   function automatic logic [7:0] rand_cmd();
      logic [31:0] r = $urandom;
      case (r[2:0])
         3'd0, 3'd1: return {3'b000, 5'(r[15:8])};
         3'd2:       return {2'b01, 6'(r[15:8])};
         3'd3:       return {3'b001, 5'(r[15:8])};
         3'd4:       return {1'b1, 7'(r[15:8])};
         default:    return r[15:8];
      endcase
   endfunction

   initial begin
      #(200000 * 5);
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20417));
      repeat (3) @(posedge clk);
      #1;
      chk("R1 flags after reset", flags_out, 32'h0);
      chk("R1 irq after reset", {31'b0, irq}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      rd_chk("R1 flag read after reset", FLAG_A, 32'h0);

      cyc("R2 set two channels", 1'b0, CMD_A, 32'h0, 4'h0, 32'h8000_0001);
      cyc("R2 set all", 1'b0, CMD_A, 32'h0, 4'h0, 32'hFFFF_FFFF);
      rd_chk("R2 flag readback", FLAG_A, 32'hFFFF_FFFF);
      cyc("R3 clear channel 5", 1'b1, CMD_A, 32'h0000_0005, 4'h1, 32'h0);
      cyc("R3 clear channel 31 via lane 3", 1'b1, CMD_A, 32'h1F00_0000, 4'h8, 32'h0);
      cyc("R5 reserved 40", 1'b1, CMD_A, 32'h0000_0028, 4'h1, 32'h0);
      cyc("R5 reserved 63", 1'b1, CMD_A, 32'h0000_3F00, 4'h2, 32'h0);
      cyc("R6 no-op 0x85", 1'b1, CMD_A, 32'h0085_0000, 4'h4, 32'h0);
      cyc("R6 no-op 0xC0", 1'b1, CMD_A, 32'h0000_00C0, 4'h1, 32'h0);
      cyc("R7 disabled lane ignored", 1'b1, CMD_A, 32'h0009_0000, 4'hB, 32'h0);
      cyc("R7 packed word", 1'b1, CMD_A, 32'h1E11_8003, 4'hF, 32'h0);
      cyc("R8 set beats clear", 1'b1, CMD_A, 32'h0000_0003, 4'h1, 32'h0000_0008);
      cyc("R9 write to flag address", 1'b1, FLAG_A, 32'h4040_4040, 4'hF, 32'h0);
      cyc("R9 write to other address", 1'b1, 4'd2, 32'h0000_0000, 4'hF, 32'h0);
      rd_chk("R9 command address reads zero", CMD_A, 32'h0);
      rd_chk("R9 flag read", FLAG_A, exp_f);
      cyc("R4 global 0x7F", 1'b1, CMD_A, 32'h8080_7F80, 4'hF, 32'h0);
      chk("R4 all cleared", flags_out, 32'h0);
      cyc("R2 refill", 1'b0, CMD_A, 32'h0, 4'h0, 32'hA5A5_5A5A);
      cyc("R8 set beats global", 1'b1, CMD_A, 32'h0000_0040, 4'h1, 32'h0000_0100);
      chk("R8 only new set remains", flags_out, 32'h0000_0100);

      for (int n = 0; n < 600; n++) begin
         logic [31:0] d;
         logic [3:0]  a;
         logic [31:0] s;
         d = {rand_cmd(), rand_cmd(), rand_cmd(), rand_cmd()};
         a = ($urandom % 8 == 0) ? 4'($urandom) : CMD_A;
         s = (n % 3 == 0) ? ($urandom | $urandom) : ($urandom & $urandom & $urandom);
         cyc("R7 random mix", 1'($urandom), a, d, 4'($urandom), s);
         if (n % 50 == 0) rd_chk("R9 random flag read", FLAG_A, exp_f);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule